// File: doc/BRIEF.md
# SCSI Asynchronous Byte Handshake Engine

This block moves a counted run of bytes across an asynchronous SCSI information phase from the target's side. It runs the REQ/ACK interlock for each byte. The order of events depends on the direction. When sending, the byte is placed on the data bus and held for a setup interval before REQ is raised. When receiving, REQ is raised first and the bus is sampled a settle interval after ACK arrives. The setup and settle interval is derived from a clock-frequency parameter and a nanosecond target, which defaults to 100 ns. The ACK input is expected to be already synchronised to `clk`.

Software or a surrounding controller pulses `start` with a byte count, a direction and a sector size given as a power of two. The engine splits the transfer into bursts. Each burst is one eighth of the bytes still owed, rounded down to whole sectors, never less than one sector, and never more than what remains. Scheduled pauses (`GAP_CYC` cycles with REQ low) fall only between bursts, never inside one.

Transmit bytes arrive on a valid/ready stream. A byte is taken only when `tx_valid` and `tx_ready` are both high at a clock edge. While the source has nothing, the engine waits with REQ low, so back-pressure from an empty source simply stretches the handshake. Received bytes leave on a one-cycle strobe with no ready input, because the initiator is paced by REQ and the consumer must accept one byte per handshake. An abort input ends any wait at once. A completion pulse reports the end of the transfer, and a counter reports how many bytes finished.

Top module: `scsi_async_xfer`

## Requirements
- R1: While `rst_n` is low and after its release, `req_out`, `db_oe`, `done`, `rx_valid`, `burst_start` and `tx_ready` are 0 and `bytes_done` is 0.
- R2: With `rx_mode`=0, each transmit byte appears on `db_out` with `db_oe`=1 exactly SETUP_CYC = ceil(CLK_MHZ*SETUP_NS/1000) cycles before `req_out` rises, and bytes go out in stream order.
- R3: With `rx_mode`=0, the clock edge that first sees `ack_in` high with REQ asserted drops `req_out` and `db_oe` together, and the next byte is not taken until `ack_in` has been seen low.
- R4: With `rx_mode`=1, `req_out` rises, and SETUP_CYC edges after the first edge that sees `ack_in` high, `db_in` is captured to `rx_data` with a one-cycle `rx_valid` pulse on the same edge that drops `req_out`; bytes come out in bus order.
- R5: `req_out` never rises while `ack_in` is still high from the previous byte.
- R6: `tx_ready` is high only while the engine waits for a transmit byte; while `tx_valid` stays low, `req_out` stays low.
- R7: Each burst length, shown on `burst_len` during a one-cycle `burst_start` pulse, is floor(remaining/8) rounded down to a multiple of 2^`sector_shift`, raised to at least 2^`sector_shift`, capped at the remaining count; bursts cover the transfer exactly.
- R8: After the last byte's ACK is released, `done` pulses for exactly one cycle and `bytes_done` equals `xfer_count`.
- R9: `abort` high in any active state clears `req_out` and `db_oe` at the next edge, pulses `done` once, and leaves `bytes_done` at the number of fully completed bytes; `abort` while idle has no effect.
- R10: A start with `xfer_count`=0 pulses `done` with `bytes_done`=0, no burst and no REQ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| rx_mode | input | 1 | 1 = receive from initiator, 0 = send to initiator |
| xfer_count | input | CNT_W | Number of bytes to move |
| sector_shift | input | SHIFT_W | log2 of the sector size in bytes |
| abort | input | 1 | Bus reset abort; ends the transfer |
| ack_in | input | 1 | Synchronised ACK from the initiator |
| tx_data | input | 8 | Transmit stream byte |
| tx_valid | input | 1 | Transmit stream byte available |
| tx_ready | output | 1 | Engine accepts a transmit byte this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| db_in | input | 8 | Data bus as seen from the pins |
| db_out | output | 8 | Data bus drive value |
| db_oe | output | 1 | Data bus output enable |
| req_out | output | 1 | REQ to the initiator |
| burst_start | output | 1 | One-cycle pulse when a burst begins |
| burst_len | output | CNT_W | Length of the burst just begun |
| done | output | 1 | One-cycle completion pulse |
| bytes_done | output | CNT_W | Bytes fully handshaken in the current or last transfer |

## Verification
Both directions are swept over every count from 1 to 20 at three sector sizes (1, 2 and 4 bytes). The initiator's ACK and release delays rotate with the count, so timing that depends on a fixed ACK latency would be exposed. Each byte's value and position show ordering errors, the per-byte edge distances show an off-by-one in the setup counter, and the burst sequence shows errors in the rounding, the floor of one sector and the remainder cap. Separate runs hold the transmit source empty, abort between a byte's ACK and its release, pulse abort while idle, and start with a zero count. These tell apart the stall, the completed-byte count on abort and the degenerate paths.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PLAN,
    S_TX_WAIT,
    S_TX_SETUP,
    S_TX_ACK,
    S_TX_REL,
    S_RX_ISSUE,
    S_RX_ACK,
    S_RX_SETTLE,
    S_RX_REL,
    S_GAP,
    S_DONE
  } xfer_state_e;

  // Round a nanosecond interval up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(int unsigned mhz, int unsigned ns);
    return (mhz * ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/xfer_delay.sv
module xfer_delay #(
  parameter int unsigned CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic fin
);
  localparam int unsigned LOADV = (CYCLES < 1) ? 1 : CYCLES;
  localparam int CW = $clog2(LOADV + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(LOADV);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // fin is seen on the LOADV-th edge after the load edge
  assign fin = (cnt == CW'(1));

  // A new interval only begins once the previous one has run out (R2, R4).
  assert_reload_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0));

endmodule

// File: rtl/xfer_burst_plan.sv
module xfer_burst_plan #(
  parameter int CNT_W   = 16,
  parameter int SHIFT_W = $clog2(CNT_W)
) (
  input  logic [CNT_W-1:0]   remaining,
  input  logic [SHIFT_W-1:0] shift,
  output logic [CNT_W-1:0]   len
);
  logic [CNT_W-1:0] sector;
  logic [CNT_W-1:0] share;
  logic [CNT_W-1:0] whole;

  always_comb begin
    sector = CNT_W'(1) << shift;
    share  = remaining >> 3;
    whole  = share & ~(sector - 1'b1);
    if (whole < sector)    whole = sector;
    if (whole > remaining) whole = remaining;
    len = whole;
  end

  // Every burst except a short tail is a nonzero whole number of sectors (R7).
  always_comb begin
    if (remaining != '0) begin
      assert_whole_sectors_R7: assert ((len == remaining) ||
        ((len != '0) && ((len & (sector - 1'b1)) == '0)));
    end
  end

endmodule

// File: rtl/scsi_async_xfer.sv
module scsi_async_xfer #(
  parameter int unsigned CLK_MHZ  = 200,
  parameter int unsigned SETUP_NS = 100,
  parameter int unsigned GAP_CYC  = 4,
  parameter int          CNT_W    = 16,
  localparam int         SHIFT_W  = $clog2(CNT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               rx_mode,
  input  logic [CNT_W-1:0]   xfer_count,
  input  logic [SHIFT_W-1:0] sector_shift,
  input  logic               abort,
  input  logic               ack_in,
  input  logic [7:0]         tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  input  logic [7:0]         db_in,
  output logic [7:0]         db_out,
  output logic               db_oe,
  output logic               req_out,
  output logic               burst_start,
  output logic [CNT_W-1:0]   burst_len,
  output logic               done,
  output logic [CNT_W-1:0]   bytes_done
);
  import xfer_pkg::*;

  localparam int unsigned SETUP_CYC = ns_to_cycles(CLK_MHZ, SETUP_NS);
  localparam int AGE_W = $clog2(SETUP_CYC + 1) + 1;

  xfer_state_e        state;
  logic [CNT_W-1:0]   remaining;
  logic [CNT_W-1:0]   burst_left;
  logic [CNT_W-1:0]   plan_len;
  logic [SHIFT_W-1:0] shift_q;
  logic               dir_q;
  logic               setup_fin, gap_fin;
  logic               load_setup, load_gap;
  logic               byte_end, last_byte, burst_last;
  logic               active;

  xfer_burst_plan #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_plan (
    .remaining (remaining),
    .shift     (shift_q),
    .len       (plan_len)
  );

  xfer_delay #(.CYCLES(SETUP_CYC)) u_setup (
    .clk (clk), .rst_n (rst_n), .load (load_setup), .fin (setup_fin)
  );

  xfer_delay #(.CYCLES(GAP_CYC)) u_gap (
    .clk (clk), .rst_n (rst_n), .load (load_gap), .fin (gap_fin)
  );

  assign active     = (state != S_IDLE) && (state != S_DONE);
  assign last_byte  = (remaining == CNT_W'(1));
  assign burst_last = (burst_left == CNT_W'(1));
  assign byte_end   = ((state == S_TX_REL) || (state == S_RX_REL)) && !ack_in && !abort;
  assign load_setup = !abort && (((state == S_TX_WAIT) && tx_valid) ||
                                 ((state == S_RX_ACK) && ack_in));
  assign load_gap   = byte_end && !last_byte && burst_last;
  assign tx_ready   = (state == S_TX_WAIT) && !abort;
  assign done       = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      remaining   <= '0;
      burst_left  <= '0;
      shift_q     <= '0;
      dir_q       <= 1'b0;
      bytes_done  <= '0;
      req_out     <= 1'b0;
      db_oe       <= 1'b0;
      db_out      <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      burst_start <= 1'b0;
      burst_len   <= '0;
    end else begin
      rx_valid    <= 1'b0;
      burst_start <= 1'b0;
      if (abort && active) begin
        req_out <= 1'b0;
        db_oe   <= 1'b0;
        state   <= S_DONE;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            bytes_done <= '0;
            dir_q      <= rx_mode;
            shift_q    <= sector_shift;
            remaining  <= xfer_count;
            state      <= (xfer_count == '0) ? S_DONE : S_PLAN;
          end
          S_PLAN: begin
            burst_left  <= plan_len;
            burst_len   <= plan_len;
            burst_start <= 1'b1;
            state       <= dir_q ? S_RX_ISSUE : S_TX_WAIT;
          end
          S_TX_WAIT: if (tx_valid) begin
            db_out <= tx_data;
            db_oe  <= 1'b1;
            state  <= S_TX_SETUP;
          end
          S_TX_SETUP: if (setup_fin) begin
            req_out <= 1'b1;
            state   <= S_TX_ACK;
          end
          S_TX_ACK: if (ack_in) begin
            req_out <= 1'b0;
            db_oe   <= 1'b0;
            db_out  <= '0;
            state   <= S_TX_REL;
          end
          S_RX_ISSUE: begin
            req_out <= 1'b1;
            state   <= S_RX_ACK;
          end
          S_RX_ACK: if (ack_in) state <= S_RX_SETTLE;
          S_RX_SETTLE: if (setup_fin) begin
            rx_data  <= db_in;
            rx_valid <= 1'b1;
            req_out  <= 1'b0;
            state    <= S_RX_REL;
          end
          S_TX_REL, S_RX_REL: if (!ack_in) begin
            bytes_done <= bytes_done + 1'b1;
            remaining  <= remaining - 1'b1;
            burst_left <= burst_left - 1'b1;
            if (last_byte)       state <= S_DONE;
            else if (burst_last) state <= S_GAP;
            else                 state <= dir_q ? S_RX_ISSUE : S_TX_WAIT;
          end
          S_GAP:  if (gap_fin) state <= S_PLAN;
          S_DONE: state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // Independent age of the driven bus, for the setup check.
  logic [AGE_W-1:0] oe_age;
  always_ff @(posedge clk) begin
    if (!rst_n || !db_oe)                 oe_age <= '0;
    else if (oe_age != AGE_W'(SETUP_CYC)) oe_age <= oe_age + 1'b1;
  end

  assert_setup_before_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_out) && db_oe) |-> (oe_age >= AGE_W'(SETUP_CYC)));

  assert_release_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out && db_oe && ack_in) |=> (!req_out && !db_oe));

  assert_rx_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_wait_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !req_out) |=> !req_out);

  assert_stall_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> !req_out);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!req_out && !db_oe));

endmodule

// File: tb/tb_scsi_async_xfer.sv
`timescale 1ns/1ps
module tb_scsi_async_xfer;
  localparam int SETUP = 20;   // 100 ns at 200 MHz
  localparam int CW    = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rx_mode = 1'b0, abort = 1'b0, ack = 1'b0;
  logic [CW-1:0] xfer_count = '0;
  logic [3:0]    sector_shift = '0;
  logic [7:0]    tx_data = '0, db_in = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready, rx_valid, db_oe, req, burst_start, done;
  logic [7:0]    rx_data, db_out;
  logic [CW-1:0] burst_len, bytes_done;

  always #2.5 clk = ~clk;

  scsi_async_xfer #(.CLK_MHZ(200), .SETUP_NS(100), .GAP_CYC(4), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode), .xfer_count(xfer_count),
    .sector_shift(sector_shift), .abort(abort), .ack_in(ack), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .req_out(req),
    .burst_start(burst_start), .burst_len(burst_len), .done(done), .bytes_done(bytes_done)
  );

  int vectors = 0, fails = 0, cyc = 0;
  int txq[$], rxq[$], bq[$];
  int done_cnt = 0, src_idx = 0, src_total = 0, src_en = 0, hs_pend = 0;
  int seed = 0, rx_idx = 0, ack_dly = 0, rel_dly = 0, dcnt = 0;
  int t_oe = 0, t_ack = 0, req_seen = 0, r3_pend = 0;
  logic req_prev = 1'b0, oe_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pat(int s, int i);
    return (s * 7 + i * 13 + 5) & 255;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // Monitor, transmit source and initiator model, all at the falling edge.
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (r3_pend != 0) begin
        chk(!req && !db_oe, "R3", int'({req, db_oe}), 0);
        r3_pend = 0;
      end
      if (rx_valid) begin
        rxq.push_back(int'(rx_data));
        chk(cyc - t_ack == SETUP + 1, "R4", cyc - t_ack, SETUP + 1);
        chk(!req, "R4", int'(req), 0);
      end
      if (burst_start) bq.push_back(int'(burst_len));
      if (done) done_cnt++;
      if (req) req_seen = 1;
      if (db_oe && !oe_prev) t_oe = cyc;
      if (req && !req_prev) begin
        chk(!ack, "R5", int'(ack), 0);
        if (db_oe) chk(cyc - t_oe == SETUP, "R2", cyc - t_oe, SETUP);
      end
      req_prev = req;
      oe_prev  = db_oe;
    end
    if (hs_pend != 0) src_idx++;
    tx_valid = (src_en != 0) && (src_idx < src_total);
    tx_data  = 8'(pat(seed, src_idx));
    hs_pend  = int'(tx_valid && tx_ready);
    if (req && !ack) begin
      if (dcnt >= ack_dly) begin
        ack = 1'b1; dcnt = 0; t_ack = cyc;
        if (db_oe) begin
          txq.push_back(int'(db_out));
          r3_pend = 1;
        end else begin
          db_in = 8'(pat(seed, rx_idx));
          rx_idx++;
        end
      end else dcnt++;
    end else if (!req && ack) begin
      if (dcnt >= rel_dly) begin ack = 1'b0; dcnt = 0; end
      else dcnt++;
    end else dcnt = 0;
  end

  task automatic prep(input bit rx, input int n, input int sh, input int ad, input int rd, input int en);
    while (ack) @(posedge clk);
    @(posedge clk); #1;
    txq.delete(); rxq.delete(); bq.delete();
    done_cnt = 0; req_seen = 0; src_idx = 0; hs_pend = 0; rx_idx = 0;
    src_total = n; seed = n * 3 + sh * 31 + (rx ? 11 : 0);
    ack_dly = ad; rel_dly = rd; src_en = rx ? 0 : en;
    rx_mode = rx; xfer_count = CW'(n); sector_shift = 4'(sh);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done_cnt == 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic check_xfer(input bit rx, input int n, input int sh);
    int exp_b[$];
    int r, m, sec;
    chk(done_cnt == 1, "R8", done_cnt, 1);
    chk(int'(bytes_done) == n, "R8", int'(bytes_done), n);
    if (rx) begin
      chk(rxq.size() == n, "R4", rxq.size(), n);
      foreach (rxq[i]) chk(rxq[i] == pat(seed, i), "R4", rxq[i], pat(seed, i));
    end else begin
      chk(txq.size() == n, "R2", txq.size(), n);
      foreach (txq[i]) chk(txq[i] == pat(seed, i), "R2", txq[i], pat(seed, i));
    end
    sec = 1 << sh;
    r = n;
    while (r > 0) begin
      m = (r / 8) & ~(sec - 1);
      if (m < sec) m = sec;
      if (m > r) m = r;
      exp_b.push_back(m);
      r -= m;
    end
    chk(bq.size() == exp_b.size(), "R7", bq.size(), exp_b.size());
    foreach (exp_b[i]) if (i < bq.size()) chk(bq[i] == exp_b[i], "R7", bq[i], exp_b[i]);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk(!req && !db_oe && !done && !rx_valid && !burst_start, "R1", int'({req, db_oe, done, rx_valid, burst_start}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!req && !db_oe && !done && !rx_valid && !tx_ready && !burst_start, "R1",
        int'({req, db_oe, done, rx_valid, tx_ready, burst_start}), 0);
    chk(bytes_done == '0, "R1", int'(bytes_done), 0);

    // Sweep both directions over counts and sector sizes.
    for (int sh = 0; sh < 3; sh++)
      for (int d = 0; d < 2; d++)
        for (int n = 1; n <= 20; n++) begin
          prep(d[0], n, sh, n % 3, (n + 1) % 3, 1);
          wait_done();
          check_xfer(d[0], n, sh);
        end

    // R10: zero-length transfer.
    prep(1'b0, 0, 2, 0, 0, 1);
    wait_done();
    chk(done_cnt == 1, "R10", done_cnt, 1);
    chk(bytes_done == '0, "R10", int'(bytes_done), 0);
    chk(req_seen == 0, "R10", req_seen, 0);
    chk(bq.size() == 0, "R10", bq.size(), 0);

    // R6: empty transmit source stalls REQ.
    prep(1'b0, 3, 0, 1, 1, 0);
    repeat (40) @(posedge clk);
    #1;
    chk(tx_ready, "R6", int'(tx_ready), 1);
    chk(req_seen == 0, "R6", req_seen, 0);
    src_en = 1;
    wait_done();
    check_xfer(1'b0, 3, 0);

    // R9: abort between the fifth ACK and its release.
    prep(1'b0, 20, 2, 1, 8, 1);
    while (txq.size() < 5) @(posedge clk);
    #1;
    abort = 1'b1;
    @(posedge clk); #1;
    abort = 1'b0;
    wait_done();
    chk(done_cnt == 1, "R9", done_cnt, 1);
    chk(int'(bytes_done) == 4, "R9", int'(bytes_done), 4);
    chk(!req && !db_oe, "R9", int'({req, db_oe}), 0);

    // R9: abort while idle is ignored.
    while (ack) @(posedge clk);
    @(posedge clk); #1;
    done_cnt = 0;
    abort = 1'b1;
    @(posedge clk); #1;
    abort = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk(done_cnt == 0, "R9", done_cnt, 0);
    chk(!req && int'(bytes_done) == 4, "R9", int'(bytes_done), 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule